// File: doc/BRIEF.md
# Programmable Counter Array Timer

The block is a shared 16-bit up-counter feeding five identical compare/capture channels. On each cycle the counter advances by at most one step. The step comes from one of four count sources: a divide-by-6 enable strobe, a divide-by-2 enable strobe, an overflow pulse from a neighbouring timer, or an external count pin. The counter moves only while its run bit is set. When it wraps from FFFFh to 0000h it raises a sticky overflow flag.

Each channel can be set up in several ways:
- It can latch the counter when an edge arrives on its capture pin.
- It can work as a 16-bit software timer that flags the cycle in which the counter steps onto its compare value.
- It can also toggle its output pin on that match, as a high-speed output.
- It can drive an 8-bit PWM. The duty takes effect only when the counter's low byte wraps.

A byte-wide register port gives access to the control, flag, counter and per-channel registers. A single interrupt line combines all enabled flags.

Register map (5-bit address):
- 00h control: bit0 run, bit1 overflow interrupt enable, bits3:2 source.
- 01h flags.
- 02h/03h counter low/high.
- 08h+n mode of channel n.
- 10h+2n low byte and 11h+2n high byte of channel n.

Top module: `pca_array`

## Requirements
- R1: After reset the counter, all mode, compare and flag registers read 0, every output pin is 0 and the interrupt is 0.
- R2: Source field (control bits3:2) 0 selects the divide-by-6 strobe, 1 the divide-by-2 strobe, 2 the timer-overflow pulse and 3 a falling edge on the external count pin (two-flop synchronised). The counter rises by exactly one per selected event while control bit0 (run) is 1, and holds while it is 0.
- R3: A step from FFFFh sets flags bit7 and gives 0000h. The interrupt follows that flag only while control bit1 is 1.
- R4: With mode bit0 (rising) and/or bit1 (falling) set, a synchronised edge of the chosen polarity on the channel's capture pin copies the counter into its high/low bytes and sets flags bit n. An edge of a polarity that is not enabled changes nothing.
- R5: With mode bit2 (comparator enable) and bit3 (match) set and bit5 clear, the counter stepping onto {high,low} sets flags bit n. With bit2 clear, no flag is set.
- R6: When mode bit4 (toggle) is also set, each such match inverts the channel's output pin, and the pin holds between matches.
- R7: A channel flag drives the interrupt only while its mode bit6 is 1.
- R8: A write to a channel's low byte clears its mode bit2, and a write to its high byte sets it.
- R9: With mode bit5 (PWM) and bit2 both set, the output pin is 0 while counter[7:0] < low byte and 1 otherwise.
- R10: In PWM mode the low byte is reloaded from the high byte only when the counter's low byte steps from FFh to 00h. A new high-byte value does not change the duty before then.
- R11: Writing 1 to a flags bit clears it. Writing 0 leaves it unchanged.
- R12: Writes to 02h/03h load the counter bytes, and reads return the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div6 | input | 1 | Divide-by-6 count enable strobe |
| tick_div2 | input | 1 | Divide-by-2 count enable strobe |
| t0_ovf | input | 1 | Neighbouring timer overflow pulse |
| ext_count | input | 1 | External count pin, falling edge counts |
| cap_in | input | N_CH | Capture pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_out | output | N_CH | Channel outputs (toggle or PWM) |
| irq | output | 1 | Combined interrupt |

## Verification
The PWM reload is the hardest case to reach from the ports. It needs a channel already in PWM mode, a pending high byte that differs from the active duty, and the counter walked one step at a time across the FFh-to-00h boundary of its low byte. The stimulus loads the counter to 00F0h, writes the new duty, and checks that the duty has not moved. It then steps through every count up to the wrap and confirms that the duty changes exactly there. Capture results are made deterministic by stopping the counter first, so the synchroniser latency cannot alter the captured value. The PWM level is swept over all 256 low-byte counts for several duties on every channel.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int ADR_W = 5;
  localparam logic [ADR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADR_W-1:0] A_FLAGS = 5'h01;
  localparam logic [ADR_W-1:0] A_CNT_L = 5'h02;
  localparam logic [ADR_W-1:0] A_CNT_H = 5'h03;
  localparam logic [ADR_W-1:0] A_MODE0 = 5'h08;
  localparam logic [ADR_W-1:0] A_REG0  = 5'h10;

  // mode register bit positions
  localparam int MB_CAPP = 0;
  localparam int MB_CAPN = 1;
  localparam int MB_CMP  = 2;
  localparam int MB_MAT  = 3;
  localparam int MB_TOG  = 4;
  localparam int MB_PWM  = 5;
  localparam int MB_IE   = 6;

  // control register bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_OVIE = 1;
  localparam int CB_SRC  = 2;
  localparam int FB_OVF  = 7;

  typedef enum logic [1:0] {
    SRC_DIV6 = 2'd0,
    SRC_DIV2 = 2'd1,
    SRC_T0   = 2'd2,
    SRC_EXT  = 2'd3
  } src_t;
endpackage

// File: rtl/pca_tick_sel.sv
module pca_tick_sel
  import pca_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       div6,
  input  logic       div2,
  input  logic       t0,
  input  logic       ext_pin,
  output logic       tick
);
  // [0] first sync stage, [1] second sync stage, [2] previous value
  logic [2:0] ext_q;
  logic       ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[1:0], ext_pin};
  end

  assign ext_fall = ext_q[2] & ~ext_q[1];

  always_comb begin
    unique case (src_t'(sel))
      SRC_DIV6: tick = div6;
      SRC_DIV2: tick = div2;
      SRC_T0:   tick = t0;
      default:  tick = ext_fall;
    endcase
  end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int B_W   = 8,
  parameter int CNT_W = 2 * B_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_ctrl,
  input  logic             wr_cnt_l,
  input  logic             wr_cnt_h,
  input  logic             clr_ovf,
  input  logic [B_W-1:0]   wdata,
  output logic             run,
  output logic             ovf_ie,
  output logic [1:0]       src_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             ovf_flag
);
  // a register load takes priority over a count step in the same cycle
  assign adv = run & tick & ~wr_cnt_l & ~wr_cnt_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ovf_ie   <= 1'b0;
      src_sel  <= '0;
      cnt      <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run     <= wdata[CB_RUN];
        ovf_ie  <= wdata[CB_OVIE];
        src_sel <= wdata[CB_SRC +: 2];
      end
      if (adv) begin
        cnt <= cnt + 1'b1;
      end else begin
        if (wr_cnt_l) cnt[B_W-1:0]     <= wdata;
        if (wr_cnt_h) cnt[CNT_W-1:B_W] <= wdata;
      end
      ovf_flag <= (adv && cnt == '1) | (ovf_flag & ~clr_ovf);
    end
  end
endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
#(
  parameter int B_W   = 8,
  parameter int CNT_W = 2 * B_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             adv,
  input  logic             wr_mode,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [B_W-1:0]   wdata,
  input  logic             clr_flag,
  input  logic             cap_pin,
  output logic [B_W-1:0]   mode_rd,
  output logic [B_W-1:0]   lo_q,
  output logic [B_W-1:0]   hi_q,
  output logic             flag_q,
  output logic             ie_q,
  output logic             pwm_on,
  output logic             cmp_en_q,
  output logic             cap_evt,
  output logic             pin
);
  logic capp, capn, mat, tog, pwm, hso_q;
  logic [2:0] cs;
  logic [CNT_W-1:0] cnt_nxt;
  logic rise, fall, match_evt, wrap;

  assign cnt_nxt   = cnt + 1'b1;
  assign rise      = cs[1] & ~cs[2];
  assign fall      = ~cs[1] & cs[2];
  assign cap_evt   = (rise & capp) | (fall & capn);
  assign pwm_on    = pwm & cmp_en_q;
  assign match_evt = adv & cmp_en_q & mat & ~pwm & (cnt_nxt == {hi_q, lo_q});
  assign wrap      = adv & (cnt[B_W-1:0] == '1);
  assign pin       = pwm_on ? (cnt[B_W-1:0] >= lo_q) : hso_q;
  assign mode_rd   = B_W'({1'b0, ie_q, pwm, tog, mat, cmp_en_q, capn, capp});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs       <= '0;
      flag_q   <= 1'b0;
      hso_q    <= 1'b0;
      {ie_q, pwm, tog, mat, cmp_en_q, capn, capp} <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      cs     <= {cs[1:0], cap_pin};
      flag_q <= cap_evt | match_evt | (flag_q & ~clr_flag);
      if (match_evt & tog) hso_q <= ~hso_q;
      if (wr_mode) begin
        capp     <= wdata[MB_CAPP];
        capn     <= wdata[MB_CAPN];
        cmp_en_q <= wdata[MB_CMP];
        mat      <= wdata[MB_MAT];
        tog      <= wdata[MB_TOG];
        pwm      <= wdata[MB_PWM];
        ie_q     <= wdata[MB_IE];
      end
      if (wr_lo) cmp_en_q <= 1'b0;
      if (wr_hi) cmp_en_q <= 1'b1;
      if (cap_evt) begin
        {hi_q, lo_q} <= cnt;
      end else begin
        if (pwm_on && wrap) lo_q <= hi_q;
        if (wr_lo) lo_q <= wdata;
        if (wr_hi) hi_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/pca_array.sv
module pca_array
  import pca_pkg::*;
#(
  parameter int N_CH   = 5,
  parameter int B_W    = 8,
  parameter int ADDR_W = ADR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_div6,
  input  logic              tick_div2,
  input  logic              t0_ovf,
  input  logic              ext_count,
  input  logic [N_CH-1:0]   cap_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [B_W-1:0]    reg_wdata,
  output logic [B_W-1:0]    reg_rdata,
  output logic [N_CH-1:0]   pin_out,
  output logic              irq
);
  localparam int CNT_W = 2 * B_W;
  localparam int PAD_W = B_W - 1 - N_CH;

  logic run, ovf_ie, tick, adv, ovf_flag, cnt_load, clr_ovf;
  logic wr_ctrl, wr_flags, wr_cnt_l, wr_cnt_h;
  logic [1:0] src_sel;
  logic [CNT_W-1:0] cnt;
  logic [N_CH-1:0] ch_flag, ch_ie, ch_pwm, ch_cmp, ch_cap, ch_wr_lo, clr_ch;
  logic [N_CH-1:0][B_W-1:0] ch_mode, ch_lo, ch_hi;

  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_flags = reg_wr && reg_addr == A_FLAGS;
  assign wr_cnt_l = reg_wr && reg_addr == A_CNT_L;
  assign wr_cnt_h = reg_wr && reg_addr == A_CNT_H;
  assign cnt_load = wr_cnt_l | wr_cnt_h;
  assign clr_ovf  = wr_flags & reg_wdata[FB_OVF];
  assign clr_ch   = wr_flags ? reg_wdata[N_CH-1:0] : '0;

  pca_tick_sel u_sel (
    .clk(clk), .rst_n(rst_n), .sel(src_sel), .div6(tick_div6), .div2(tick_div2),
    .t0(t0_ovf), .ext_pin(ext_count), .tick(tick)
  );

  pca_timebase #(.B_W(B_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_ctrl(wr_ctrl), .wr_cnt_l(wr_cnt_l),
    .wr_cnt_h(wr_cnt_h), .clr_ovf(clr_ovf), .wdata(reg_wdata), .run(run),
    .ovf_ie(ovf_ie), .src_sel(src_sel), .cnt(cnt), .adv(adv), .ovf_flag(ovf_flag)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] AM = ADDR_W'(A_MODE0 + i);
    localparam logic [ADDR_W-1:0] AL = ADDR_W'(A_REG0 + 2 * i);
    localparam logic [ADDR_W-1:0] AH = ADDR_W'(A_REG0 + 2 * i + 1);
    assign ch_wr_lo[i] = reg_wr && reg_addr == AL;
    pca_channel #(.B_W(B_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .adv(adv),
      .wr_mode(reg_wr && reg_addr == AM), .wr_lo(ch_wr_lo[i]),
      .wr_hi(reg_wr && reg_addr == AH), .wdata(reg_wdata), .clr_flag(clr_ch[i]),
      .cap_pin(cap_in[i]), .mode_rd(ch_mode[i]), .lo_q(ch_lo[i]), .hi_q(ch_hi[i]),
      .flag_q(ch_flag[i]), .ie_q(ch_ie[i]), .pwm_on(ch_pwm[i]), .cmp_en_q(ch_cmp[i]),
      .cap_evt(ch_cap[i]), .pin(pin_out[i])
    );
  end

  assign irq = (ovf_flag & ovf_ie) | (|(ch_flag & ch_ie));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)  reg_rdata = B_W'({src_sel, ovf_ie, run});
    if (reg_addr == A_FLAGS) reg_rdata = {ovf_flag, {PAD_W{1'b0}}, ch_flag};
    if (reg_addr == A_CNT_L) reg_rdata = cnt[B_W-1:0];
    if (reg_addr == A_CNT_H) reg_rdata = cnt[CNT_W-1:B_W];
    for (int i = 0; i < N_CH; i++) begin
      if (reg_addr == ADDR_W'(A_MODE0 + i))     reg_rdata = ch_mode[i];
      if (reg_addr == ADDR_W'(A_REG0 + 2*i))    reg_rdata = ch_lo[i];
      if (reg_addr == ADDR_W'(A_REG0 + 2*i + 1)) reg_rdata = ch_hi[i];
    end
  end
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
  parameter int N_CH  = 5,
  parameter int B_W   = 8,
  parameter int CNT_W = 2 * B_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run,
  input logic                     adv,
  input logic                     cnt_load,
  input logic [CNT_W-1:0]         cnt,
  input logic                     ovf_flag,
  input logic [N_CH-1:0]          ch_flag,
  input logic [N_CH-1:0]          clr_ch,
  input logic [N_CH-1:0]          ch_wr_lo,
  input logic [N_CH-1:0]          ch_cmp,
  input logic [N_CH-1:0]          ch_pwm,
  input logic [N_CH-1:0]          ch_cap,
  input logic [N_CH-1:0][B_W-1:0] ch_lo
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_ovf_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == '1) |=> (ovf_flag && cnt == '0));

  p_lo_wr_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_wr_lo) |=> ((ch_cmp & $past(ch_wr_lo)) == '0));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ch_flag) & ~$past(clr_ch)) & ~ch_flag) == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    p_duty_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_pwm[i] && !ch_wr_lo[i] && !ch_cap[i] && !(adv && cnt[B_W-1:0] == '1))
        |=> $stable(ch_lo[i]));
  end
endmodule

bind pca_array pca_checker #(.N_CH(N_CH), .B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .adv(adv), .cnt_load(cnt_load), .cnt(cnt),
  .ovf_flag(ovf_flag), .ch_flag(ch_flag), .clr_ch(clr_ch), .ch_wr_lo(ch_wr_lo),
  .ch_cmp(ch_cmp), .ch_pwm(ch_pwm), .ch_cap(ch_cap), .ch_lo(ch_lo)
);

// File: tb/sim_pca_array.sv
module sim_pca_array;
  localparam int N = 5;
  logic clk = 0, rst_n = 0;
  logic tick_div6 = 0, tick_div2 = 0, t0_ovf = 0, ext_count = 1;
  logic [N-1:0] cap_in = '0;
  logic reg_wr = 0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] pin_out;
  logic irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pca_array u0 (
    .clk(clk), .rst_n(rst_n), .tick_div6(tick_div6), .tick_div2(tick_div2),
    .t0_ovf(t0_ovf), .ext_count(ext_count), .cap_in(cap_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 5'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 5'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic setcnt(input int v);
    wr(2, v & 8'hFF);
    wr(3, (v >> 8) & 8'hFF);
  endtask

  task automatic rdcnt(output int v);
    int l, h;
    rd(2, l); rd(3, h);
    v = (h << 8) | l;
  endtask

  // k: 0 div6, 1 div2, 2 timer overflow, 3 external pin falling edge
  task automatic pulse(input int k);
    if (k == 3) begin
      @(negedge clk); ext_count = 0;
      repeat (4) @(negedge clk);
      ext_count = 1;
      repeat (4) @(negedge clk);
    end else begin
      @(negedge clk);
      tick_div6 = (k == 0); tick_div2 = (k == 1); t0_ovf = (k == 2);
      @(negedge clk);
      tick_div6 = 0; tick_div2 = 0; t0_ovf = 0;
    end
  endtask

  task automatic setcap(input int m, input logic v);
    @(negedge clk); cap_in[m] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v, exp_c, cmpv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rdcnt(v); chk("R1 counter", v, 0);
    rd(1, v); chk("R1 flags", v, 0);
    rd(0, v); chk("R1 control", v, 0);
    for (int m = 0; m < N; m++) begin
      rd(8 + m, v); chk("R1 mode", v, 0);
      rd(16 + 2*m, v); chk("R1 low byte", v, 0);
    end
    chk("R1 pins", int'(pin_out), 0);
    chk("R1 irq", int'(irq), 0);

    // R12 counter load and readback
    setcnt(16'h1234); rdcnt(v); chk("R12 load", v, 16'h1234);
    setcnt(16'hBEEF); rdcnt(v); chk("R12 reload", v, 16'hBEEF);

    // R2 source select sweep
    for (int s = 0; s < 4; s++) begin
      wr(0, (s << 2) | 1);
      setcnt(0);
      exp_c = 0;
      for (int k = 0; k < 4; k++) begin
        pulse(k);
        if (k == s) exp_c++;
        rdcnt(v); chk("R2 source sweep", v, exp_c);
      end
      wr(0, s << 2);
      pulse(s);
      rdcnt(v); chk("R2 stopped", v, exp_c);
    end

    // R3 overflow, R11 flag clearing
    wr(0, (1 << 2) | 1);
    setcnt(16'hFFFF);
    pulse(1);
    rdcnt(v); chk("R3 wrap value", v, 0);
    rd(1, v); chk("R3 flag set", v, 8'h80);
    chk("R3 irq masked", int'(irq), 0);
    wr(0, (1 << 2) | 3);
    chk("R3 irq enabled", int'(irq), 1);
    wr(1, 8'h00);
    rd(1, v); chk("R11 write zero keeps", v, 8'h80);
    wr(1, 8'h80);
    rd(1, v); chk("R11 clear", v, 0);
    chk("R3 irq after clear", int'(irq), 0);
    wr(0, 0);

    for (int m = 0; m < N; m++) begin
      // R4 capture
      wr(0, 0);
      setcnt(16'h0A50 + m);
      wr(8 + m, 8'h01);
      setcap(m, 1);
      rd(16 + 2*m, v); chk("R4 rise low", v, 8'h50 + m);
      rd(17 + 2*m, v); chk("R4 rise high", v, 8'h0A);
      rd(1, v); chk("R4 flag", v, 1 << m);
      wr(1, 1 << m);
      setcnt(16'h0B00 + m);
      setcap(m, 0);
      rd(17 + 2*m, v); chk("R4 fall ignored", v, 8'h0A);
      rd(1, v); chk("R4 no flag", v, 0);
      wr(8 + m, 8'h03);
      setcap(m, 1);
      rd(17 + 2*m, v); chk("R4 both rise", v, 8'h0B);
      setcnt(16'h0C00 + m);
      setcap(m, 0);
      rd(17 + 2*m, v); chk("R4 both fall", v, 8'h0C);
      wr(1, 1 << m);
      wr(8 + m, 8'h02);
      setcnt(16'h0D00 + m);
      setcap(m, 1);
      rd(17 + 2*m, v); chk("R4 rise ignored", v, 8'h0C);
      setcap(m, 0);
      rd(17 + 2*m, v); chk("R4 neg only fall", v, 8'h0D);
      wr(1, 1 << m);
      wr(8 + m, 0);

      // R8, R5, R6, R7 match path
      cmpv = 16'h3020 + m * 16'h0111;
      wr(8 + m, 8'h18);
      wr(16 + 2*m, cmpv & 8'hFF);
      rd(8 + m, v); chk("R8 low clears", v, 8'h18);
      wr(17 + 2*m, cmpv >> 8);
      rd(8 + m, v); chk("R8 high sets", v, 8'h1C);
      wr(16 + 2*m, cmpv & 8'hFF);
      rd(8 + m, v); chk("R8 low clears again", v, 8'h18);
      wr(17 + 2*m, cmpv >> 8);
      setcnt(cmpv - 2);
      wr(0, (1 << 2) | 1);
      pulse(1);
      rd(1, v); chk("R5 before match", v, 0);
      chk("R6 pin before", int'(pin_out[m]), 0);
      pulse(1);
      rd(1, v); chk("R5 match flag", v, 1 << m);
      chk("R6 pin toggled", int'(pin_out[m]), 1);
      chk("R7 irq masked", int'(irq), 0);
      wr(8 + m, 8'h5C);
      chk("R7 irq enabled", int'(irq), 1);
      wr(1, 1 << m);
      chk("R7 irq cleared", int'(irq), 0);
      pulse(1);
      rd(1, v); chk("R5 past match", v, 0);
      chk("R6 pin holds", int'(pin_out[m]), 1);
      wr(16 + 2*m, cmpv & 8'hFF);
      setcnt(cmpv - 1);
      pulse(1);
      rd(1, v); chk("R5 comparator off", v, 0);
      chk("R6 pin no toggle", int'(pin_out[m]), 1);
      wr(0, 0);
      wr(8 + m, 0);

      // R9 PWM level sweep
      wr(8 + m, 8'h24);
      for (int d = 0; d < 256; d += 51) begin
        wr(16 + 2*m, d);
        wr(17 + 2*m, d);
        for (int c = 0; c < 256; c++) begin
          wr(2, c);
          chk("R9 pwm level", int'(pin_out[m]), (c >= d) ? 1 : 0);
        end
      end
      wr(8 + m, 0);
    end

    // R10 reload only at low-byte wrap
    wr(8, 8'h24);
    wr(16, 8'h40);
    wr(17, 8'h40);
    setcnt(16'h00F0);
    wr(17, 8'hC0);
    rd(16, v); chk("R10 no early reload", v, 8'h40);
    chk("R10 pin old duty", int'(pin_out[0]), 1);
    wr(0, (1 << 2) | 1);
    for (int i = 0; i < 15; i++) pulse(1);
    rdcnt(v); chk("R10 at FF", v, 16'h00FF);
    rd(16, v); chk("R10 held before wrap", v, 8'h40);
    pulse(1);
    rd(16, v); chk("R10 reloaded", v, 8'hC0);
    chk("R10 pin new duty", int'(pin_out[0]), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule